// File: doc/BRIEF.md
# Snapshot Exposure Line Sequencer

This block is the timing engine of an image sensor that offers a snapshot mode, in which the exposure is timed from outside the sensor. A free-running pixel counter sets the line period, which is chosen by a mode input. The counter drives a line-sync pulse at the start of every line. When snapshot mode is off, the block produces continuous frames. Each frame starts with a one-line vertical sync, then a fixed run of invalid head lines, then the valid lines, which are marked by a line-valid strobe.

When snapshot mode is on, an external master raises an exposure gate. The block synchronizes the gate and waits for the next line boundary. It then holds a precharge phase for a parameterised number of lines and moves to exposure. Exposure lasts until the gate falls, and the block sees the fall at a line boundary, so exposure length is resolved in whole lines. One readout frame follows, after which the block waits idle for the next gate. If the gate falls before precharge has finished, the block raises a short-exposure flag and returns to idle without a readout.

A hardware power-down clears the counters. A software power-down freezes them while the clock keeps running.

Top module: `frame_snapshot_seq`

## Requirements
- R1: The line period is LINE_A clocks when `mode_sel`=0 and LINE_B clocks when `mode_sel`=1. `hsync` is high for the first HS_W clocks of each line, so its rising edges are exactly one line period apart.
- R2: With `frex_en` low, frames repeat continuously with a period of (HEAD+FRAME) lines. `vsync` rises on the first line boundary after reset.
- R3: While idle with `frex_en` high, a rising edge of `frex_gate` is passed through a two-flop synchronizer. Precharge then starts on the first line boundary (hsync rising edge) at least three clocks after the gate change, and `precharge` stays high for exactly PRE lines. `precharge` and `href` are never high together.
- R4: After precharge, exposure continues while the synchronized gate is high. Readout starts on the first line boundary at least three clocks after the gate falls. `vsync` is high for exactly the first line of readout.
- R5: Readout sends HEAD lines with `href` low, then FRAME lines with `href` high, which is FRAME×period clocks of `href` in total. `line_idx` counts readout lines from 0 and equals HEAD on the first valid line.
- R6: After the last valid line, the block returns to idle when `frex_en` is high. In idle `href`, `vsync` and `precharge` are low and `line_idx` is 0 until the next gate rising edge.
- R7: If the synchronized gate is low at a line boundary during precharge, `short_err` goes high, precharge ends at that boundary and no readout follows. `short_err` stays high until the next precharge starts.
- R8: While `sw_pdn` is high, the pixel counter, line counter and phase are frozen. Every later line boundary is delayed by the number of frozen clocks.
- R9: While `hw_pdn` is high, the counters clear: `line_idx`=0, the block is idle, and `hsync` is high because the pixel count is 0.
- R10: After reset, `hsync`=1, `line_idx`=0, and `vsync`, `href`, `precharge` and `short_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_pdn | input | 1 | Hardware power-down, clears the counters |
| sw_pdn | input | 1 | Software power-down, freezes activity |
| mode_sel | input | 1 | Line-period select (0: LINE_A, 1: LINE_B) |
| frex_en | input | 1 | Snapshot mode enable |
| frex_gate | input | 1 | Exposure gate from the external master |
| hsync | output | 1 | Line sync pulse |
| href | output | 1 | Line-valid strobe |
| vsync | output | 1 | One-line frame sync at the start of readout |
| precharge | output | 1 | Array precharge phase |
| short_err | output | 1 | Gate released before precharge finished |
| line_idx | output | $clog2(HEAD+FRAME) | Readout line counter |

## Verification
The assertions assume that `mode_sel` does not change mid-line and that HEAD is at least one. They also assume that `hw_pdn` takes priority over `sw_pdn` whenever both are high. The stimulus keeps `mode_sel` constant between resets and never raises both power-down inputs together. It changes the gate only after a falling clock edge. The gate offset within a line is swept across every clock position, so both sides of the three-clock synchronizer window are covered.

// File: rtl/frame_snapshot_seq.sv
module frame_snapshot_seq #(
  parameter int LINE_A = 3296,
  parameter int LINE_B = 858,
  parameter int HS_W   = 64,
  parameter int HEAD   = 8,
  parameter int FRAME  = 612,
  parameter int PRE    = 2,
  localparam int TOTAL = HEAD + FRAME,
  localparam int LW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_pdn,
  input  logic          sw_pdn,
  input  logic          mode_sel,
  input  logic          frex_en,
  input  logic          frex_gate,
  output logic          hsync,
  output logic          href,
  output logic          vsync,
  output logic          precharge,
  output logic          short_err,
  output logic [LW-1:0] line_idx
);
  localparam int PW  = $clog2((LINE_A > LINE_B ? LINE_A : LINE_B) + 1);
  localparam int PRW = $clog2(PRE + 1);

  typedef enum logic [1:0] {IDLE, PRE_CH, EXPO, READ} st_t;

  st_t            st;
  logic [PW-1:0]  pix;
  logic [LW-1:0]  line;
  logic [PRW-1:0] pre;
  logic [1:0]     en_q, gt_q;
  logic           gt_d, arm, err;

  wire en_s = en_q[1];
  wire gs   = gt_q[1];
  wire rise = gs & ~gt_d;
  wire [PW-1:0] last = mode_sel ? PW'(LINE_B - 1) : PW'(LINE_A - 1);
  wire wrap = pix >= last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= '0;
      gt_q <= '0;
      gt_d <= 1'b0;
    end else begin
      en_q <= {en_q[0], frex_en};
      gt_q <= {gt_q[0], frex_gate};
      gt_d <= gt_q[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; pix <= '0; line <= '0; pre <= '0; arm <= 1'b0; err <= 1'b0;
    end else if (hw_pdn) begin
      st <= IDLE; pix <= '0; line <= '0; pre <= '0; arm <= 1'b0; err <= 1'b0;
    end else if (!sw_pdn) begin
      pix <= wrap ? '0 : pix + 1'b1;
      if (st == IDLE && rise) arm <= 1'b1;
      if (wrap)
        case (st)
          IDLE:
            if (!en_s) begin
              st <= READ; line <= '0; arm <= 1'b0;
            end else if (arm || rise) begin
              st <= PRE_CH; pre <= PRW'(PRE - 1); arm <= 1'b0; err <= 1'b0;
            end
          PRE_CH:
            if (!en_s) begin
              st <= READ; line <= '0;
            end else if (!gs) begin
              st <= IDLE; err <= 1'b1;
            end else if (pre == '0) st <= EXPO;
            else pre <= pre - 1'b1;
          EXPO:
            if (!en_s || !gs) begin
              st <= READ; line <= '0;
            end
          READ:
            if (line == LW'(TOTAL - 1)) begin
              line <= '0;
              if (en_s) st <= IDLE;
            end else line <= line + 1'b1;
          default: st <= IDLE;
        endcase
    end

  assign hsync     = pix < PW'(HS_W);
  assign precharge = st == PRE_CH;
  assign vsync     = st == READ && line == '0;
  assign href      = st == READ && line >= LW'(HEAD);
  assign short_err = err;
  assign line_idx  = line;

  assert_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_pdn && !sw_pdn && !wrap) |=> $stable(st));
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pdn && !hw_pdn) |=> ($stable(pix) && $stable(line) && $stable(st)));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_pdn |=> (pix == '0 && line == '0 && st == IDLE));
  assert_err_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_err) |-> $past(st) == PRE_CH);
  assert_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(href) |-> ($past(line) == LW'(HEAD - 1) && line == LW'(HEAD)));
endmodule

// File: tb/test_frame_snapshot_seq.sv
module test_frame_snapshot_seq;
  localparam int LA = 24, LB = 14, HSW = 2, HEAD = 3, FRAME = 6, PRE = 2;
  localparam int TOTAL = HEAD + FRAME;
  localparam int LW = $clog2(TOTAL);

  logic clk = 0, rst_n = 0, hw_pdn = 0, sw_pdn = 0, mode_sel = 0, frex_en = 0, frex_gate = 0;
  logic hsync, href, vsync, precharge, short_err;
  logic [LW-1:0] line_idx;

  frame_snapshot_seq #(.LINE_A(LA), .LINE_B(LB), .HS_W(HSW), .HEAD(HEAD), .FRAME(FRAME), .PRE(PRE))
    i_frame_snapshot_seq (.clk, .rst_n, .hw_pdn, .sw_pdn, .mode_sel, .frex_en, .frex_gate,
      .hsync, .href, .vsync, .precharge, .short_err, .line_idx);

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, L, h0;
  int pre_rise, pre_fall, vs_rise, vs_rise2, vs_fall, href_first, href_last, href_n, hs_last, li_at_href;
  logic p_pre, p_vs, p_href, p_hs;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    pre_rise = -1; pre_fall = -1; vs_rise = -1; vs_rise2 = -1; vs_fall = -1;
    href_first = -1; href_last = -1; href_n = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    if (precharge && !p_pre) pre_rise = cyc;
    if (!precharge && p_pre) pre_fall = cyc;
    if (vsync && !p_vs) begin
      if (vs_rise < 0) vs_rise = cyc; else if (vs_rise2 < 0) vs_rise2 = cyc;
    end
    if (!vsync && p_vs && vs_fall < 0) vs_fall = cyc;
    if (href) begin
      href_n++; href_last = cyc;
      if (!p_href && href_first < 0) begin href_first = cyc; li_at_href = int'(line_idx); end
    end
    if (hsync && !p_hs) hs_last = cyc;
    p_pre = precharge; p_vs = vsync; p_href = href; p_hs = hsync;
  endtask

  function automatic int nr(int t);
    if (t <= h0) return h0;
    return h0 + ((t - h0 + L - 1) / L) * L;
  endfunction

  task automatic wait_rise();
    tick();
    while (hs_last != cyc) tick();
  endtask

  task automatic apply_reset(logic m, logic en);
    @(negedge clk);
    rst_n = 0; mode_sel = m; frex_en = en; frex_gate = 0;
    L = m ? LB : LA;
    clear_mon();
    repeat (3) tick();
    chk("R10 hsync", hsync, 1);
    chk("R10 line_idx", int'(line_idx), 0);
    chk("R10 vsync/href/precharge/short_err", {vsync, href, precharge, short_err}, 0);
    rst_n = 1;
    wait_rise();
    h0 = hs_last;
    wait_rise();
    chk("R1 line period", hs_last - h0, L);
  endtask

  task automatic shot(int off, int elines);
    int c, c2, ep;
    clear_mon();
    wait_rise();
    repeat (off) tick();
    frex_gate = 1; c = cyc;
    repeat (elines * L) tick();
    frex_gate = 0; c2 = cyc;
    repeat ((HEAD + FRAME + 3) * L) tick();
    ep = nr(c + 3);
    chk("R3 precharge start", pre_rise, ep);
    if (elines >= PRE + 2) begin
      chk("R3 precharge length", pre_fall - pre_rise, PRE * L);
      chk("R4 readout start", vs_rise, nr(c2 + 3));
      chk("R4 vsync width", vs_fall - vs_rise, L);
      chk("R5 first valid line", href_first, vs_rise + HEAD * L);
      chk("R5 line_idx at first valid", li_at_href, HEAD);
      chk("R5 valid clocks", href_n, FRAME * L);
      chk("R6 last valid clock", href_last, vs_rise + TOTAL * L - 1);
      chk("R7 no error on good shot", short_err, 0);
    end else begin
      chk("R7 short_err", short_err, 1);
      chk("R7 precharge end", pre_fall, nr(c2 + 3));
      chk("R7 no readout", vs_rise, -1);
      chk("R7 no valid data", href_n, 0);
    end
    chk("R6 idle outputs", {href, vsync, precharge}, 0);
    chk("R6 idle line_idx", int'(line_idx), 0);
  endtask

  initial begin
    p_pre = 0; p_vs = 0; p_href = 0; p_hs = 0; hs_last = -1;
    for (int m = 0; m < 2; m++) begin
      apply_reset(m[0], 1'b1);
      for (int off = 0; off < L; off++) shot(off, PRE + 2 + off % 3);
      shot(5, 1);
      shot(7, PRE + 2);
    end

    apply_reset(1'b0, 1'b0);
    while (cyc < h0 + TOTAL * L) tick();
    chk("R2 first vsync", vs_rise, h0);
    chk("R2 frame period", vs_rise2 - vs_rise, TOTAL * L);
    chk("R2 valid clocks per frame", href_n, FRAME * L);

    begin
      int s, li, bad;
      logic hs;
      repeat (5) tick();
      li = int'(line_idx); hs = hsync; s = cyc; bad = 0;
      sw_pdn = 1;
      repeat (7) begin
        tick();
        if (int'(line_idx) != li || hsync != hs) bad++;
      end
      sw_pdn = 0;
      chk("R8 frozen outputs", bad, 0);
      wait_rise();
      chk("R8 boundary delayed", hs_last, nr(s + 1) + 7);
    end

    repeat (L + 3) tick();
    hw_pdn = 1;
    repeat (2) tick();
    chk("R9 line_idx cleared", int'(line_idx), 0);
    chk("R9 hsync at count 0", hsync, 1);
    chk("R9 idle outputs", {href, vsync, precharge}, 0);
    hw_pdn = 0;
    repeat (2) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule